// File: doc/BRIEF.md
# Quad Down-Counter Timer Bank

This block holds four down-counting timers behind a 32-bit synchronous register port. Two of the timers are narrow (16 bits) and two are wide (32 bits). All four advance on one shared tick, which a programmable prescaler derives from the block clock. A timer that runs out reloads itself from its preload register and raises its own interrupt flag. A single interrupt line reports every flag whose per-timer interrupt enable is set.

Software reads the live counts through count registers. The two narrow timers share one word: the timer at index 1 sits in the upper half and the timer at index 0 in the lower half. A latch-select control bit picks one of two ways to freeze counts when they are read:

- **Grouped mode:** reading the shared word snapshots all four timers at once. The two wide-count registers then return that frozen snapshot.
- **Individual mode:** every count register captures and returns its own timer at the moment it is read.

A flag is cleared in either of two ways. Software can write any data to that timer's clear register, or it can write a 0 to the timer's bit in the status register.

Register map (byte offsets on `reg_addr`):

| Offset | Register | Contents |
|---|---|---|
| 0x00 | control | bits 3..0 timer run enables, bits 7..4 interrupt enables, bit 8 latch select |
| 0x04 | status | bits 3..0 expiry flags |
| 0x08 | prescaler divisor | bits 15..0 |
| 0x10, 0x14, 0x18, 0x1C | preloads | timers 0..3 |
| 0x20 | shared count word | timer 1 in bits 31..16, timer 0 in bits 15..0 |
| 0x24 | wide count | timer 2 |
| 0x28 | wide count | timer 3 |
| 0x30, 0x34, 0x38, 0x3C | clear registers | timers 0..3 |

Reads of any unmapped offset return 0.

Top module: `qtimer_bank`

## Requirements
- R1: After reset the following are all 0: every count, flag, run enable, interrupt enable, the latch select, the divisor, `reg_rdata` and `irq`.
- R2: The shared tick is asserted in any cycle where the prescaler counter is at least the divisor (offset 0x08, bits 15..0). In that cycle the prescaler counter returns to 0; in every other cycle it increments. With divisor D, a tick therefore occurs every D+1 cycles.
- R3: On a tick, each timer whose run enable is set (control bits 3..0) behaves as follows. If its count is 0, it loads its preload and expires. Otherwise it decrements by 1. A timer whose run enable is clear holds its count.
- R4: The preloads and counts of timers 0 and 1 are 16 bits wide; write data above bit 15 is dropped, and preload readback shows only the stored bits. Timers 2 and 3 keep all 32 bits.
- R5: A read at 0x20 returns {timer 1 count, timer 0 count}, and reads at 0x24 and 0x28 return timers 2 and 3. Every read result appears on `reg_rdata` at the clock edge that ends the read cycle. `reg_rdata` holds its value in cycles with no read.
- R6: With latch select = 1 (control bit 8), each count register returns the live count of its timer(s) from the read cycle, and stores that value as its own snapshot.
- R7: With latch select = 0, a read at 0x20 returns the live word and also snapshots all four counts. Reads at 0x24 and 0x28 then return the snapshot from the most recent such capture, not the live count.
- R8: When a timer expires, its bit in the status register (0x04, bits 3..0) is set at that edge.
- R9: A write of any data to 0x30 + 4*i clears flag i.
- R10: A status write clears each flag whose written bit is 0 and leaves unchanged each flag whose written bit is 1.
- R11: If a clear and an expiry of the same timer fall in one cycle, the flag ends up set.
- R12: `irq` is a register. It equals the OR over i of (flag i AND interrupt enable i, control bits 7..4) as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined, enable-gated interrupt |

## Verification
- **Control writes:** a write changes control, divisor, preload and flag state at the edge that ends the write cycle.
- **Reads:** the value returned by a read appears on `reg_rdata` at the same edge that ends the read cycle. It reflects the counts and flags as they stood before that edge.
- **Interrupt:** `irq` trails the flags and enables by one more edge.
- **Bench timing:** the bench drives each access on a falling edge and samples on the next falling edge. A cycle-level model, built from the requirements, steps on the same rising edge as the design, so every comparison lines up with these latencies. `irq` is compared on every cycle, not only on read cycles.

// File: rtl/qtb_pkg.sv
package qtb_pkg;
  localparam int NUM_TMR = 4;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PRE0  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT01 = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CNT2  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CNT3  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CLR0  = 8'h30;

  localparam int CTRL_LSEL_BIT = 8;

  function automatic logic [ADDR_W-1:0] ofs_idx(logic [ADDR_W-1:0] base, int idx);
    return base + ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/qtb_prescaler.sv
module qtb_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pc_q;

  assign tick = (pc_q >= div);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else if (tick) pc_q <= '0;
    else pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/qtb_timer.sv
module qtb_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic [W-1:0] preload,
  output logic [W-1:0] count,
  output logic         expire
);
  assign expire = tick && run && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (tick && run) begin
      if (count == '0) count <= preload;
      else count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/qtimer_bank.sv
module qtimer_bank
  import qtb_pkg::*;
#(
  parameter int SMALL_W = 16,
  parameter int LARGE_W = 32,
  parameter int DIV_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int HALF_W = REG_W / 2;

  logic [NUM_TMR-1:0]            run_q, ien_q, flag_q, expire, clr;
  logic                          lsel_q;
  logic [DIV_W-1:0]              div_q;
  logic                          tick;
  logic [NUM_TMR-1:0][REG_W-1:0] pre_q, snap_q, cnt_ext, wmask;
  logic [REG_W-1:0]              rd_val;
  logic                          rd_cnt01, rd_cnt2, rd_cnt3;

  qtb_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .div(div_q), .tick(tick)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int W = (i < 2) ? SMALL_W : LARGE_W;
    logic [W-1:0] cnt_w;

    qtb_timer #(.W(W)) u_tmr (
      .clk(clk), .rst(rst), .tick(tick), .run(run_q[i]),
      .preload(pre_q[i][W-1:0]), .count(cnt_w), .expire(expire[i])
    );

    always_comb begin
      cnt_ext[i]        = '0;
      cnt_ext[i][W-1:0] = cnt_w;
      wmask[i]          = '0;
      wmask[i][W-1:0]   = '1;
    end

    assign clr[i] = reg_wr && ((reg_addr == ofs_idx(OFS_CLR0, i)) ||
                               (reg_addr == OFS_STAT && !reg_wdata[i]));
  end

  // control, divisor and preload registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      ien_q  <= '0;
      lsel_q <= 1'b0;
      div_q  <= '0;
      pre_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) begin
        run_q  <= reg_wdata[NUM_TMR-1:0];
        ien_q  <= reg_wdata[2*NUM_TMR-1:NUM_TMR];
        lsel_q <= reg_wdata[CTRL_LSEL_BIT];
      end
      if (reg_addr == OFS_DIV) div_q <= reg_wdata[DIV_W-1:0];
      for (int i = 0; i < NUM_TMR; i++)
        if (reg_addr == ofs_idx(OFS_PRE0, i)) pre_q[i] <= reg_wdata & wmask[i];
    end
  end

  // flags: an expiry in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | expire;
      irq    <= |(flag_q & ien_q);
    end
  end

  // read-triggered snapshots
  assign rd_cnt01 = reg_rd && (reg_addr == OFS_CNT01);
  assign rd_cnt2  = reg_rd && (reg_addr == OFS_CNT2);
  assign rd_cnt3  = reg_rd && (reg_addr == OFS_CNT3);

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else begin
      if (rd_cnt01) begin
        snap_q[0] <= cnt_ext[0];
        snap_q[1] <= cnt_ext[1];
        if (!lsel_q) begin
          snap_q[2] <= cnt_ext[2];
          snap_q[3] <= cnt_ext[3];
        end
      end
      if (rd_cnt2 && lsel_q) snap_q[2] <= cnt_ext[2];
      if (rd_cnt3 && lsel_q) snap_q[3] <= cnt_ext[3];
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      OFS_CTRL:  begin
        rd_val[2*NUM_TMR-1:0]   = {ien_q, run_q};
        rd_val[CTRL_LSEL_BIT]   = lsel_q;
      end
      OFS_STAT:  rd_val[NUM_TMR-1:0] = flag_q;
      OFS_DIV:   rd_val[DIV_W-1:0]   = div_q;
      OFS_CNT01: rd_val = {cnt_ext[1][HALF_W-1:0], cnt_ext[0][HALF_W-1:0]};
      OFS_CNT2:  rd_val = lsel_q ? cnt_ext[2] : snap_q[2];
      OFS_CNT3:  rd_val = lsel_q ? cnt_ext[3] : snap_q[3];
      default: begin
        for (int i = 0; i < NUM_TMR; i++)
          if (reg_addr == ofs_idx(OFS_PRE0, i)) rd_val = pre_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/qtb_checker.sv
module qtb_checker
  import qtb_pkg::*;
(
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_wr,
  input logic                          reg_rd,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [REG_W-1:0]              reg_wdata,
  input logic [REG_W-1:0]              reg_rdata,
  input logic                          irq,
  input logic [NUM_TMR-1:0]            flags,
  input logic [NUM_TMR-1:0]            expire,
  input logic [NUM_TMR-1:0]            run,
  input logic [NUM_TMR-1:0][REG_W-1:0] cnt
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == 1'b0 && flags == '0 && reg_rdata == '0)); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R5

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|flags)); // R12

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    logic clr_reg, clr_stat;
    assign clr_reg  = reg_wr && (reg_addr == ofs_idx(OFS_CLR0, i));
    assign clr_stat = reg_wr && (reg_addr == OFS_STAT) && !reg_wdata[i];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !run[i] |=> $stable(cnt[i])); // R3

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
      expire[i] |=> flags[i]); // R8

    AST_CLEAR_REG: assert property (@(posedge clk) disable iff (rst)
      (clr_reg && !expire[i]) |=> !flags[i]); // R9

    AST_CLEAR_STAT: assert property (@(posedge clk) disable iff (rst)
      (clr_stat && !expire[i]) |=> !flags[i]); // R10

    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (rst)
      ((clr_reg || clr_stat) && expire[i]) |=> flags[i]); // R11
  end
endmodule

bind qtimer_bank qtb_checker u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .flags(flag_q), .expire(expire), .run(run_q), .cnt(cnt_ext)
);

// File: tb/qtimer_bank_tb_top.sv
module qtimer_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qtimer_bank dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // reference model, stepped on the same edge as the design
  logic [31:0] m_cnt[4], m_pre[4], m_snap[4];
  logic [15:0] m_pc, m_div;
  logic [3:0]  m_run, m_ien, m_flag, t_exp, t_clr;
  logic        m_lsel, m_irq, t_tick;
  logic [31:0] m_rdata;

  function automatic logic [31:0] msk(int i);
    return (i < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_pre[i] = 0; m_snap[i] = 0; end
      m_pc = 0; m_div = 0; m_run = 0; m_ien = 0; m_flag = 0;
      m_lsel = 0; m_irq = 0; m_rdata = 0;
    end else begin
      t_tick = (m_pc >= m_div);
      t_clr = 0;
      if (reg_rd) begin
        case (reg_addr)
          8'h00: m_rdata = {23'b0, m_lsel, m_ien, m_run};
          8'h04: m_rdata = {28'b0, m_flag};
          8'h08: m_rdata = {16'b0, m_div};
          8'h10, 8'h14, 8'h18, 8'h1C: m_rdata = m_pre[(reg_addr - 8'h10) >> 2];
          8'h20: begin
            m_rdata = {m_cnt[1][15:0], m_cnt[0][15:0]};
            m_snap[0] = m_cnt[0]; m_snap[1] = m_cnt[1];
            if (!m_lsel) begin m_snap[2] = m_cnt[2]; m_snap[3] = m_cnt[3]; end
          end
          8'h24: begin m_rdata = m_lsel ? m_cnt[2] : m_snap[2]; if (m_lsel) m_snap[2] = m_cnt[2]; end
          8'h28: begin m_rdata = m_lsel ? m_cnt[3] : m_snap[3]; if (m_lsel) m_snap[3] = m_cnt[3]; end
          default: m_rdata = 0;
        endcase
      end
      m_irq = |(m_flag & m_ien);
      for (int i = 0; i < 4; i++) begin
        t_exp[i] = t_tick && m_run[i] && (m_cnt[i] == 0);
        if (t_tick && m_run[i]) m_cnt[i] = (m_cnt[i] == 0) ? m_pre[i] : ((m_cnt[i] - 1) & msk(i));
      end
      m_pc = t_tick ? 16'd0 : m_pc + 16'd1;
      if (reg_wr) begin
        case (reg_addr)
          8'h00: begin m_run = reg_wdata[3:0]; m_ien = reg_wdata[7:4]; m_lsel = reg_wdata[8]; end
          8'h04: t_clr = ~reg_wdata[3:0];
          8'h08: m_div = reg_wdata[15:0];
          8'h10, 8'h14, 8'h18, 8'h1C: m_pre[(reg_addr - 8'h10) >> 2] = reg_wdata & msk((reg_addr - 8'h10) >> 2);
          8'h30, 8'h34, 8'h38, 8'h3C: t_clr[(reg_addr - 8'h30) >> 2] = 1'b1;
          default: ;
        endcase
      end
      m_flag = (m_flag & ~t_clr) | t_exp;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R3 ctrl";
      8'h04: return "R8 R9 R10 R11 status";
      8'h08: return "R2 divisor";
      8'h10, 8'h14, 8'h18, 8'h1C: return "R4 preload";
      8'h20: return "R3 R5 R6 R7 shared count";
      8'h24, 8'h28: return "R2 R5 R6 R7 wide count";
      default: return "R5 unmapped";
    endcase
  endfunction

  // one cycle: drive on a falling edge, compare on the next one
  task automatic cyc(bit wr, bit rd, logic [7:0] a, logic [31:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    if (rd) chk(tag_of(a), reg_rdata, m_rdata);
    chk("R12 irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(logic [7:0] a); cyc(0, 1, a, 0); endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) cyc(0, 0, 0, 0); endtask

  initial begin
    int timeout = 150000;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > timeout) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp<%0d", cycles, timeout);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h00); chk("R1 ctrl", reg_rdata, 32'h0);
    rd(8'h04); chk("R1 status", reg_rdata, 32'h0);
    rd(8'h20); chk("R1 counts", reg_rdata, 32'h0);
    rd(8'h28); chk("R1 count3", reg_rdata, 32'h0);

    // R4 width of narrow vs wide preloads
    wr(8'h10, 32'hABCD_1234); rd(8'h10); chk("R4 narrow preload", reg_rdata, 32'h0000_1234);
    wr(8'h18, 32'hABCD_1234); rd(8'h18); chk("R4 wide preload", reg_rdata, 32'hABCD_1234);

    // R11: preload 0 makes timer 0 expire on every tick; clears lose
    wr(8'h10, 32'h0); wr(8'h00, 32'h11); idle(3);
    wr(8'h30, 32'hDEAD_BEEF); rd(8'h04); chk("R11 flag kept", reg_rdata[0], 1'b1);
    wr(8'h04, 32'h0);         rd(8'h04); chk("R11 flag kept", reg_rdata[0], 1'b1);
    // R9 after stopping the timer the clear takes effect
    wr(8'h00, 32'h10); wr(8'h30, 32'h0); rd(8'h04); chk("R9 cleared", reg_rdata[0], 1'b0);
    idle(2); chk("R12 irq low", {31'b0, irq}, 32'h0);

    // R7 grouped snapshot: wide read returns value frozen at shared read
    wr(8'h18, 32'd1000); wr(8'h1C, 32'd2000); wr(8'h00, 32'h0C);
    idle(5); rd(8'h20); idle(7); rd(8'h24); rd(8'h28);
    // R6 individual mode
    wr(8'h00, 32'h10C); idle(4); rd(8'h24); idle(3); rd(8'h28);

    // R2 divisor 3: count changes every 4 cycles
    wr(8'h08, 32'd3); idle(9); rd(8'h24); rd(8'h24); idle(4); rd(8'h24);

    // R10 partial status clear
    wr(8'h08, 32'd0); wr(8'h10, 32'd2); wr(8'h14, 32'd3); wr(8'h00, 32'hF3);
    idle(12); wr(8'h00, 32'hF0); wr(8'h04, 32'h2); rd(8'h04);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 99);
      int t = $urandom_range(0, 3);
      if (sel < 35) idle(1);
      else if (sel < 65) begin
        logic [7:0] a;
        case ($urandom_range(0, 9))
          0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h10 + 8'(4 * t);
          4, 5: a = 8'h20; 6: a = 8'h24; 7: a = 8'h28; 8: a = 8'h04; default: a = 8'h40;
        endcase
        rd(a);
      end
      else if (sel < 72) wr(8'h00, $urandom_range(0, 511));
      else if (sel < 78) wr(8'h04, $urandom_range(0, 15));
      else if (sel < 86) wr(8'h30 + 8'(4 * t), $urandom());
      else if (sel < 90) wr(8'h08, $urandom_range(0, 3));
      else wr(8'h10 + 8'(4 * t), ($urandom_range(0, 3) == 0) ? $urandom() : $urandom_range(0, 20));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule